// File: doc/BRIEF.md
# Lane-Degrading Link Striper

This block sits between a flit source and a four-lane physical link. Each accepted flit goes to exactly one lane. Successive flits rotate over the lanes that are still healthy, visiting them in ascending lane order. A lane reported as failed is removed from the rotation at once. The rotation is then rebuilt over the lanes that remain, so the link keeps carrying traffic at three, two or one quarter of full rate instead of going down.

A minimum-width setting controls how far the link may shrink before it gives up:

- A setting of 4 turns any lane loss into a link reset.
- A setting of 1 keeps the link alive down to a single lane.

When a lane drops and the link survives, the block does three things:

- It emits a one-cycle replay pulse, so an external retry engine resends the flits that were in flight.
- It stalls the source for a programmable number of cycles.
- It restarts the rotation from the lowest healthy lane.

The block reports the active-lane mask and the active width. It raises a sticky link-reset request when the healthy count falls below the minimum.

Top module: `lane_degrade_ctrl`

## Requirements
- R1: After rst_ni is released, active_mask_o is 4'b1111, active_width_o is 4, flit_ready_o is 1, and lane_valid_o, replay_o and link_reset_o are 0.
- R2: A flit is accepted in a cycle where flit_valid_i and flit_ready_o are both 1. In the next cycle exactly one bit of lane_valid_o is set, for the lane that takes it. The flit appears on bits [lane*FLIT_W +: FLIT_W] of lane_data_o. Successive accepted flits visit the active lanes in ascending index order and wrap after the highest.
- R3: A 1 on bit n of lane_fail_i marks lane n failed. In the next cycle bit n of active_mask_o is 0 and active_width_o equals the count of ones in active_mask_o. A failed lane is never re-admitted before rst_ni is asserted.
- R4: After a lane loss that the link survives, the next accepted flit goes to the lowest-indexed healthy lane. The rotation then continues over the surviving lanes only, in ascending order.
- R5: A new lane failure that leaves the link up produces replay_o high for exactly the following cycle. A failure on a lane that is already failed produces no pulse. A failure that takes the link down produces no pulse.
- R6: flit_ready_o is 0 in the cycle in which a new lane failure is presented. It stays 0 for the next hold_cycles_i cycles, and then returns to 1.
- R7: If a new failure leaves fewer healthy lanes than the minimum width, link_reset_o rises in the next cycle and stays high until reset. While it is high, active_mask_o and active_width_o read 0, flit_ready_o is 0, and lane_valid_o stays 0. min_width_i is clamped into 1..4, so 0 acts as 1.
- R8: With min_width_i = 4, any single lane failure raises link_reset_o. With min_width_i = 1, the link keeps running on one lane.
- R9: A flit offered while flit_ready_o is 0 is not accepted: lane_valid_o is 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| min_width_i | input | 3 | Minimum lane count the link may run on |
| hold_cycles_i | input | 8 | Stall length after a lane loss |
| lane_fail_i | input | 4 | Per-lane failure indication |
| flit_valid_i | input | 1 | Source offers a flit |
| flit_i | input | 16 | Flit payload |
| flit_ready_o | output | 1 | Flit can be taken this cycle |
| lane_valid_o | output | 4 | One-hot: lane carrying a flit this cycle |
| lane_data_o | output | 64 | Per-lane flit data, lane n at [n*16 +: 16] |
| active_mask_o | output | 4 | Lanes currently in the rotation |
| active_width_o | output | 3 | Number of active lanes |
| replay_o | output | 1 | One-cycle request to replay in-flight flits |
| link_reset_o | output | 1 | Sticky request to reset the link |

## Verification
The assertions assume that min_width_i and hold_cycles_i stay constant between resets. Under that assumption, an active link always has a nonzero width and the hold counter never sees a configuration change mid-stall.

The bench sets both values only while rst_ni is low. It then leaves them alone for the whole run. Lane failures arrive as sparse random single-lane events, plus directed multi-lane and repeated-lane events.

// File: rtl/lane_deg_pkg.sv
package lane_deg_pkg;
  typedef enum logic [1:0] {
    HS_RUN  = 2'd0,
    HS_HOLD = 2'd1,
    HS_DOWN = 2'd2
  } hold_state_e;

  function automatic int unsigned ones4(input logic [3:0] v);
    int unsigned n;
    n = 0;
    for (int i = 0; i < 4; i++) n += int'(v[i]);
    return n;
  endfunction
endpackage

// File: rtl/ldc_lane_health.sv
module ldc_lane_health #(
  parameter int LANES = 4,
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LANES-1:0] lane_fail_i,
  input  logic [CNT_W-1:0] min_width_i,
  output logic [LANES-1:0] healthy_o,
  output logic             event_o,
  output logic             drop_o,
  output logic             down_o,
  output logic             replay_o
);
  logic [LANES-1:0] failed_q, fail_nxt, new_fail;
  logic [CNT_W-1:0] min_eff, cnt_nxt;
  logic             down_q, replay_q;

  always_comb begin
    if (min_width_i == '0) min_eff = CNT_W'(1);
    else if (min_width_i > CNT_W'(LANES)) min_eff = CNT_W'(LANES);
    else min_eff = min_width_i;
  end

  assign new_fail = lane_fail_i & ~failed_q;
  assign fail_nxt = failed_q | lane_fail_i;

  always_comb begin
    cnt_nxt = '0;
    for (int l = 0; l < LANES; l++) cnt_nxt += CNT_W'(!fail_nxt[l]);
  end

  assign event_o = (|new_fail) && !down_q;
  assign drop_o  = event_o && (cnt_nxt < min_eff);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      failed_q <= '0;
      down_q   <= 1'b0;
      replay_q <= 1'b0;
    end else begin
      failed_q <= fail_nxt;
      down_q   <= down_q | drop_o;
      replay_q <= event_o && !drop_o;
    end
  end

  assign healthy_o = down_q ? '0 : ~failed_q;
  assign down_o    = down_q;
  assign replay_o  = replay_q;

  // failed lanes are never re-admitted
  assert_no_readmit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (failed_q & ~$past(failed_q)) == (failed_q & ~$past(failed_q)) &&
    ($past(failed_q) & ~failed_q) == '0);

  assert_replay_only_up_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_q |-> !down_q);
endmodule

// File: rtl/ldc_hold_ctrl.sv
module ldc_hold_ctrl
  import lane_deg_pkg::*;
#(
  parameter int HOLD_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              event_i,
  input  logic              drop_i,
  input  logic [HOLD_W-1:0] hold_cycles_i,
  output logic              stall_o
);
  hold_state_e       state_q, state_d;
  logic [HOLD_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (drop_i) begin
      state_d = HS_DOWN;
      cnt_d   = '0;
    end else if (event_i) begin
      cnt_d   = hold_cycles_i;
      state_d = (hold_cycles_i == '0) ? HS_RUN : HS_HOLD;
    end else if (state_q == HS_HOLD) begin
      cnt_d = cnt_q - 1'b1;
      if (cnt_q == HOLD_W'(1)) state_d = HS_RUN;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= HS_RUN;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign stall_o = (state_q != HS_RUN) || event_i;

  assert_hold_nonzero_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_HOLD) |-> (cnt_q != '0));

  assert_down_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == HS_DOWN) |=> (state_q == HS_DOWN));
endmodule

// File: rtl/ldc_stripe_map.sv
module ldc_stripe_map #(
  parameter int LANES = 4,
  parameter int IDX_W = $clog2(LANES),
  parameter int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0]            healthy_i,
  output logic [LANES-1:0][IDX_W-1:0] slot_lane_o,
  output logic [CNT_W-1:0]            width_o
);
  // slot k -> k-th healthy lane, ascending
  always_comb begin
    logic [CNT_W-1:0] n;
    n = '0;
    slot_lane_o = '0;
    for (int l = 0; l < LANES; l++) begin
      if (healthy_i[l]) begin
        slot_lane_o[n[IDX_W-1:0]] = IDX_W'(l);
        n = n + 1'b1;
      end
    end
    width_o = n;
  end
endmodule

// File: rtl/ldc_striper.sv
module ldc_striper #(
  parameter int LANES  = 4,
  parameter int FLIT_W = 16,
  parameter int IDX_W  = $clog2(LANES),
  parameter int CNT_W  = $clog2(LANES + 1)
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        accept_i,
  input  logic                        restart_i,
  input  logic [FLIT_W-1:0]           flit_i,
  input  logic [LANES-1:0][IDX_W-1:0] slot_lane_i,
  input  logic [CNT_W-1:0]            width_i,
  output logic [LANES-1:0]            lane_valid_o,
  output logic [LANES*FLIT_W-1:0]     lane_data_o
);
  logic [IDX_W-1:0] ptr_q;
  logic [IDX_W-1:0] tgt;
  logic [LANES-1:0] sel;
  logic [LANES-1:0] valid_q;

  assign tgt = slot_lane_i[ptr_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (restart_i) ptr_q <= '0;
    else if (accept_i) begin
      if ((CNT_W'(ptr_q) + 1'b1) >= width_i) ptr_q <= '0;
      else ptr_q <= ptr_q + 1'b1;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign sel[g] = accept_i && (tgt == IDX_W'(g));
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        valid_q[g]                         <= 1'b0;
        lane_data_o[g*FLIT_W +: FLIT_W]    <= '0;
      end else begin
        valid_q[g] <= sel[g];
        if (sel[g]) lane_data_o[g*FLIT_W +: FLIT_W] <= flit_i;
      end
    end
  end

  assign lane_valid_o = valid_q;

  assert_onehot_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lane_valid_o));

  assert_ptr_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept_i && !restart_i) |-> (CNT_W'(ptr_q) < width_i));
endmodule

// File: rtl/lane_degrade_ctrl.sv
module lane_degrade_ctrl #(
  parameter int LANES  = 4,
  parameter int FLIT_W = 16,
  parameter int HOLD_W = 8,
  localparam int IDX_W = $clog2(LANES),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [CNT_W-1:0]        min_width_i,
  input  logic [HOLD_W-1:0]       hold_cycles_i,
  input  logic [LANES-1:0]        lane_fail_i,
  input  logic                    flit_valid_i,
  input  logic [FLIT_W-1:0]       flit_i,
  output logic                    flit_ready_o,
  output logic [LANES-1:0]        lane_valid_o,
  output logic [LANES*FLIT_W-1:0] lane_data_o,
  output logic [LANES-1:0]        active_mask_o,
  output logic [CNT_W-1:0]        active_width_o,
  output logic                    replay_o,
  output logic                    link_reset_o
);
  logic [LANES-1:0]            healthy;
  logic                        evt, drop, down, stall, accept;
  logic [LANES-1:0][IDX_W-1:0] slot_lane;
  logic [CNT_W-1:0]            width;

  ldc_lane_health #(.LANES(LANES)) u_health (
    .clk_i, .rst_ni, .lane_fail_i, .min_width_i,
    .healthy_o(healthy), .event_o(evt), .drop_o(drop),
    .down_o(down), .replay_o(replay_o)
  );

  ldc_hold_ctrl #(.HOLD_W(HOLD_W)) u_hold (
    .clk_i, .rst_ni, .event_i(evt), .drop_i(drop),
    .hold_cycles_i, .stall_o(stall)
  );

  ldc_stripe_map #(.LANES(LANES)) u_map (
    .healthy_i(healthy), .slot_lane_o(slot_lane), .width_o(width)
  );

  assign flit_ready_o = !stall;
  assign accept       = flit_valid_i && flit_ready_o;

  ldc_striper #(.LANES(LANES), .FLIT_W(FLIT_W)) u_stripe (
    .clk_i, .rst_ni, .accept_i(accept), .restart_i(evt), .flit_i,
    .slot_lane_i(slot_lane), .width_i(width),
    .lane_valid_o, .lane_data_o
  );

  assign active_mask_o  = healthy;
  assign active_width_o = width;
  assign link_reset_o   = down;

  assert_valid_on_active_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lane_valid_o & ~active_mask_o) == '0);

  assert_mask_monotone_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_mask_o & ~$past(active_mask_o)) == '0);

  assert_width_matches_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(active_mask_o) == int'(active_width_o));

  assert_reset_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_reset_o |=> link_reset_o);

  assert_reset_quiet_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_reset_o |=> (lane_valid_o == '0 && !flit_ready_o));

  assert_up_has_lane_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !link_reset_o |-> (active_width_o != '0));

  assert_replay_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    replay_o |-> !link_reset_o);
endmodule

// File: tb/sim_lane_degrade_ctrl.sv
module sim_lane_degrade_ctrl;
  localparam int FW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    min_w = 3'd1;
  logic [7:0]    hold = 8'd0;
  logic [3:0]    fail = '0;
  logic          fv = 1'b0;
  logic [FW-1:0] fd = '0;
  logic          ready;
  logic [3:0]    lvalid, amask;
  logic [4*FW-1:0] ldata;
  logic [2:0]    awidth;
  logic          replay, lreset;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // model state
  logic [3:0] m_failed;
  bit         m_down;
  int         m_hold, m_ptr, m_min, m_h;

  always #4 clk = ~clk;

  lane_degrade_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .min_width_i(min_w), .hold_cycles_i(hold),
    .lane_fail_i(fail), .flit_valid_i(fv), .flit_i(fd), .flit_ready_o(ready),
    .lane_valid_o(lvalid), .lane_data_o(ldata), .active_mask_o(amask),
    .active_width_o(awidth), .replay_o(replay), .link_reset_o(lreset)
  );

  function automatic int cnt1(input logic [3:0] v);
    int n = 0;
    for (int i = 0; i < 4; i++) n += int'(v[i]);
    return n;
  endfunction

  function automatic int kth_lane(input logic [3:0] h, input int k);
    int n = 0;
    for (int i = 0; i < 4; i++) if (h[i]) begin
      if (n == k) return i;
      n++;
    end
    return 0;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic do_reset(input int mw, input int hc);
    @(negedge clk);
    rst_n = 1'b0; min_w = 3'(mw); hold = 8'(hc); fail = '0; fv = 1'b0;
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    m_failed = '0; m_down = 0; m_hold = 0; m_ptr = 0; m_h = hc;
    m_min = (mw == 0) ? 1 : (mw > 4 ? 4 : mw);
    #1;
    chk("R1", {60'd0, amask}, 64'hf);
    chk("R1", {61'd0, awidth}, 64'd4);
    chk("R1", {63'd0, ready}, 64'd1);
    chk("R1", {60'd0, lvalid}, 64'd0);
    chk("R1", {62'd0, replay, lreset}, 64'd0);
  endtask

  task automatic step(input logic v, input logic [FW-1:0] d, input logic [3:0] f,
                      input string tag);
    logic [3:0] nf;
    bit e_ready, e_valid, e_rep;
    int e_lane;
    @(negedge clk);
    fv = v; fd = d; fail = f;
    #1;
    nf = f & ~m_failed;
    e_ready = !m_down && m_hold == 0 && nf == 0;
    chk((m_down ? "R7" : "R6"), {63'd0, ready}, {63'd0, e_ready});
    e_valid = 0; e_rep = 0; e_lane = 0;
    if (!m_down && nf != 0) begin
      m_failed |= f;
      if (cnt1(~m_failed) < m_min) m_down = 1;
      else e_rep = 1;
      m_hold = m_h; m_ptr = 0;
    end else begin
      m_failed |= f;
      if (m_hold > 0) m_hold--;
      if (e_ready && v) begin
        e_valid = 1;
        e_lane = kth_lane(~m_failed, m_ptr);
        m_ptr = (m_ptr + 1 >= cnt1(~m_failed)) ? 0 : m_ptr + 1;
      end
    end
    @(posedge clk); #1;
    chk((e_valid ? tag : "R9"), {60'd0, lvalid}, e_valid ? (64'd1 << e_lane) : 64'd0);
    if (e_valid) chk(tag, {48'd0, ldata[e_lane*FW +: FW]}, {48'd0, d});
    chk((m_down ? "R7" : "R3"), {60'd0, amask}, m_down ? 64'd0 : {60'd0, ~m_failed});
    chk((m_down ? "R7" : "R3"), {61'd0, awidth}, m_down ? 64'd0 : 64'(cnt1(~m_failed)));
    chk("R5", {63'd0, replay}, {63'd0, e_rep});
    chk("R7", {63'd0, lreset}, {63'd0, m_down});
  endtask

  initial begin
    void'($urandom(32'h1a2b3c4d));
    // directed: degrade to one lane, then down (R2, R3, R4, R5, R6, R8)
    do_reset(1, 2);
    for (int i = 0; i < 8; i++) step(1, 16'h100 + 16'(i), 4'b0000, "R2");
    step(1, 16'hdead, 4'b0010, "R3");
    for (int i = 0; i < 3; i++) step(1, 16'h200 + 16'(i), 4'b0000, "R6");
    for (int i = 0; i < 6; i++) step(1, 16'h300 + 16'(i), 4'b0000, "R4");
    step(1, 16'h400, 4'b0010, "R5");
    step(1, 16'h401, 4'b0000, "R5");
    step(1, 16'h402, 4'b1001, "R4");
    for (int i = 0; i < 6; i++) step(1, 16'h500 + 16'(i), 4'b0000, "R8");
    step(1, 16'h600, 4'b0100, "R7");
    for (int i = 0; i < 4; i++) step(1, 16'h700 + 16'(i), 4'b0000, "R9");
    // min width 4: any loss resets (R8)
    do_reset(4, 0);
    step(1, 16'h800, 4'b0000, "R8");
    step(1, 16'h801, 4'b1000, "R8");
    step(1, 16'h802, 4'b0000, "R8");
    // min width 3, zero hold, then drop below (R6, R7)
    do_reset(3, 0);
    step(1, 16'h900, 4'b0001, "R6");
    for (int i = 0; i < 4; i++) step(1, 16'h910 + 16'(i), 4'b0000, "R4");
    step(0, 16'h920, 4'b0100, "R7");
    step(1, 16'h921, 4'b0000, "R7");
    // min width 0 acts as 1 (R7)
    do_reset(0, 1);
    step(1, 16'ha00, 4'b0111, "R7");
    for (int i = 0; i < 4; i++) step(1, 16'ha10 + 16'(i), 4'b0000, "R7");
    // random runs
    for (int r = 0; r < 8; r++) begin
      do_reset(1 + ($urandom % 4), $urandom % 6);
      for (int s = 0; s < 400; s++) begin
        logic [3:0] f;
        f = (($urandom % 40) == 0) ? (4'b0001 << ($urandom % 4)) : 4'b0000;
        step(($urandom % 4) != 0, 16'($urandom), f, "R2");
      end
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule